// File: doc/BRIEF.md
# Mode-Dependent Five-Pin Port with Bus-Strobe Sharing

This block controls five shared I/O pins. Each pin can be a general input, a general output driven from a data register, or the carrier of a bus-control strobe. The strobe can be a chip select, an output-enable strobe, or a DRAM column strobe, and the bus controller outside this block produces it. Software sets the port up through three registers on a simple synchronous bus. A write-only direction register sets each pin's role. A read/write data register holds the general output levels. A read-only register returns the pin levels.

The direction register's reset value depends on the operating mode, which the block captures while power-on reset is asserted. Only power-on reset and hardware standby reinitialise the direction register. A manual reset leaves it intact. In software standby, a hold option decides whether pins that carry bus strobes freeze at their last level or float. Tri-state control is exposed as separate output-value and output-enable vectors for the pad ring.

Top module: `gpio_mux_port`

## Requirements
- R1: While `rst_n` is low with `rst_por` high, the block captures `mode`, clears the data register, and loads the direction register with only bit 4 set when the captured mode is 4 or 5. For any other mode it loads 0.
- R2: While `rst_n` is low with `rst_por` low (manual reset), the direction register keeps its value and the data register clears to 0.
- R3: While `hw_standby` is high, every `pin_oe` bit is 0. The direction register reloads its R1 value from the mode captured at the last power-on reset, and the data register clears.
- R4: On a rising edge with `bus_wr` high, `bus_idx` = 0 writes `bus_wdata[4:0]` to the direction register and `bus_idx` = 1 writes it to the data register. Writes at index 2 or 3 change nothing. `bus_rdata` is combinational: index 0 reads 0x00, index 1 reads {000, data}, index 2 reads {000, `pin_in`}, and index 3 reads 0x00.
- R5: In captured modes 4 to 6, a pin k in 1..4 whose direction bit is 1 is enabled and drives `bus_ctl_n[k-1]`.
- R6: In captured modes 4 to 6 with `dram_en` high, pin 0 is enabled and drives `cas_n`, whatever its direction bit holds.
- R7: A pin not claimed by R5 or R6 is a general pin. When its direction bit is 1 it is enabled and drives its data bit. When its direction bit is 0 its enable is 0. A pin whose enable is 0 has `pin_out` 0.
- R8: In captured modes other than 4 to 6, every pin is a general pin, even when its direction bit is 1 or `dram_en` is high.
- R9: While `sw_standby` is high with `hold_en` high, a strobe-carrying pin stays enabled and drives the strobe level sampled at the last rising edge before standby began.
- R10: While `sw_standby` is high with `hold_en` low, strobe-carrying pins have enable 0. General pins are unaffected, and normal strobe output resumes when standby ends.
- R11: Changes on `mode` outside power-on reset do not alter the captured mode. A later hardware standby reloads from the captured mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset request, active low, synchronous |
| rst_por | input | 1 | Reset type: 1 power-on, 0 manual |
| hw_standby | input | 1 | Hardware standby, active high |
| sw_standby | input | 1 | Software standby, active high |
| hold_en | input | 1 | Strobe pins keep their level in software standby |
| mode | input | 3 | Operating mode, captured during power-on reset |
| dram_en | input | 1 | DRAM interface enabled, claims pin 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | 2 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_ctl_n | input | 4 | Bus strobes; bit k goes to pin k+1 |
| cas_n | input | 1 | DRAM column strobe for pin 0 |
| pin_in | input | 5 | Pad input levels |
| pin_out | output | 5 | Pad output levels |
| pin_oe | output | 5 | Pad output enables |

## Verification
The bench forces power-on resets in modes 4, 5, 6 and 7. A design that decoded the mode wrongly would enable pin 4 in the wrong modes. A design that ignored `rst_por` would lose the direction setting across a manual reset.

Software standby is entered on the same edge on which the strobes change. A hold path that sampled late would show the new strobe levels instead of the frozen ones, and a wrong `hold_en` polarity would float or drive the wrong pins. Pin 0 is run with the DRAM strobe both on and off and with its direction bit cleared. A mode change without a power-on reset, followed by hardware standby, exposes a design that reloads from the live mode pins.

// File: rtl/gport_pkg.sv
package gport_pkg;

    typedef enum logic [1:0] {
        IDX_DIR  = 2'd0,
        IDX_DATA = 2'd1,
        IDX_PINS = 2'd2,
        IDX_RSVD = 2'd3
    } reg_idx_e;

    // Modes in which set direction bits hand pins to bus strobes
    function automatic logic mode_is_bus(input int unsigned m);
        return (m >= 4) && (m <= 6);
    endfunction

    // Modes in which the top pin comes out of power-on reset as a strobe
    function automatic logic mode_dir_hi(input int unsigned m);
        return (m == 4) || (m == 5);
    endfunction

endpackage

// File: rtl/gport_regs.sv
module gport_regs #(
    parameter int unsigned NPIN   = 5,
    parameter int unsigned DW     = 8,
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_por,
    input  logic              hw_standby,
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [DW-1:0]     wdata,
    output logic [NPIN-1:0]   dir_o,
    output logic [NPIN-1:0]   data_o,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic [NPIN-1:0]   dir;
        logic [NPIN-1:0]   data;
        logic [MODE_W-1:0] mode;
        logic              por_seen;
    } regs_t;

    regs_t s_d, s_q;

    function automatic logic [NPIN-1:0] dir_reset(input logic [MODE_W-1:0] m);
        logic [NPIN-1:0] v;
        v = '0;
        v[NPIN-1] = gport_pkg::mode_dir_hi(32'(m));
        return v;
    endfunction

    always_comb begin
        s_d = s_q;
        if (!rst_n && rst_por) begin
            s_d.mode     = mode;
            s_d.dir      = dir_reset(mode);
            s_d.data     = '0;
            s_d.por_seen = 1'b1;
        end else if (hw_standby) begin
            s_d.dir  = dir_reset(s_q.mode);
            s_d.data = '0;
        end else if (!rst_n) begin
            s_d.data = '0;
        end else if (wr_en) begin
            case (gport_pkg::reg_idx_e'(wr_idx))
                gport_pkg::IDX_DIR:  s_d.dir  = wdata[NPIN-1:0];
                gport_pkg::IDX_DATA: s_d.data = wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign dir_o  = s_q.dir;
    assign data_o = s_q.data;
    assign mode_o = s_q.mode;

    // R1: power-on reset loads the mode-dependent direction value
    p_por_init_r1: assert property (@(posedge clk) disable iff (hw_standby)
        (!rst_n && rst_por) |=> (s_q.dir == dir_reset($past(mode))));

    // R2: manual reset leaves direction untouched
    p_manual_keep_r2: assert property (@(posedge clk) disable iff (!s_q.por_seen)
        (!rst_n && !rst_por && !hw_standby) |=> $stable(s_q.dir));

endmodule

// File: rtl/gport_pin_mux.sv
module gport_pin_mux #(
    parameter int unsigned NPIN   = 5,
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [NPIN-1:0]   dir,
    input  logic [NPIN-1:0]   data,
    input  logic              dram_en,
    input  logic [NPIN-2:0]   bus_ctl_n,
    input  logic              cas_n,
    input  logic              sw_standby,
    input  logic              hold_en,
    input  logic              hw_standby,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    typedef struct packed {
        logic [NPIN-1:0] held;
    } hold_t;

    hold_t h_d, h_q;

    logic [NPIN-1:0] alt_src;
    logic [NPIN-1:0] alt_sel;
    logic            bus_mode;

    assign alt_src  = {bus_ctl_n, cas_n};
    assign bus_mode = gport_pkg::mode_is_bus(32'(mode));

    for (genvar g = 0; g < NPIN; g++) begin : g_sel
        if (g == 0) begin : g_cas
            assign alt_sel[g] = bus_mode && dram_en;
        end else begin : g_ctl
            assign alt_sel[g] = bus_mode && dir[g];
        end
    end

    // Strobe levels follow the bus controller until standby freezes them
    always_comb begin
        h_d = h_q;
        if (!rst_n)
            h_d.held = '1;
        else if (!sw_standby)
            h_d.held = alt_src;
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            if (hw_standby) begin
                pin_oe[i]  = 1'b0;
                pin_out[i] = 1'b0;
            end else if (alt_sel[i]) begin
                if (sw_standby) begin
                    pin_oe[i]  = hold_en;
                    pin_out[i] = hold_en & h_q.held[i];
                end else begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = alt_src[i];
                end
            end else begin
                pin_oe[i]  = dir[i];
                pin_out[i] = dir[i] & data[i];
            end
        end
    end

    // R3: hardware standby floats every pin
    p_hw_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |-> (pin_oe == '0));

    // R6: DRAM strobe owns pin 0 in bus modes
    p_cas_pin0_r6: assert property (@(posedge clk) disable iff (!rst_n || hw_standby || sw_standby)
        (bus_mode && dram_en) |-> (pin_oe[0] && (pin_out[0] == cas_n)));

    // R9: held strobes do not move during standby while the setup is unchanged
    p_stby_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_standby && $past(sw_standby) && hold_en && $past(hold_en)
         && !hw_standby && !$past(hw_standby) && $stable(alt_sel)
         && $stable(dir) && $stable(data)) |-> $stable(pin_out));

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
    parameter int unsigned NPIN   = 5,
    parameter int unsigned DW     = 8,
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_por,
    input  logic              hw_standby,
    input  logic              sw_standby,
    input  logic              hold_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              dram_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_idx,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPIN-2:0]   bus_ctl_n,
    input  logic              cas_n,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    localparam int unsigned PAD_W = DW - NPIN;

    logic [NPIN-1:0]   dir_w;
    logic [NPIN-1:0]   data_w;
    logic [MODE_W-1:0] mode_w;

    gport_regs #(.NPIN(NPIN), .DW(DW), .MODE_W(MODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_por    (rst_por),
        .hw_standby (hw_standby),
        .mode       (mode),
        .wr_en      (bus_wr),
        .wr_idx     (bus_idx),
        .wdata      (bus_wdata),
        .dir_o      (dir_w),
        .data_o     (data_w),
        .mode_o     (mode_w)
    );

    gport_pin_mux #(.NPIN(NPIN), .MODE_W(MODE_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_w),
        .dir        (dir_w),
        .data       (data_w),
        .dram_en    (dram_en),
        .bus_ctl_n  (bus_ctl_n),
        .cas_n      (cas_n),
        .sw_standby (sw_standby),
        .hold_en    (hold_en),
        .hw_standby (hw_standby),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    always_comb begin
        case (gport_pkg::reg_idx_e'(bus_idx))
            gport_pkg::IDX_DATA: bus_rdata = {{PAD_W{1'b0}}, data_w};
            gport_pkg::IDX_PINS: bus_rdata = {{PAD_W{1'b0}}, pin_in};
            default:             bus_rdata = '0;
        endcase
    end

    // R4: the write-only and reserved indices read as zero
    p_rd_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_idx == 2'd0) || (bus_idx == 2'd3)) |-> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
    logic       clk = 1'b0;
    logic       rst_n, rst_por, hw_standby, sw_standby, hold_en, dram_en;
    logic [2:0] mode;
    logic       bus_wr;
    logic [1:0] bus_idx;
    logic [7:0] bus_wdata, bus_rdata;
    logic [3:0] bus_ctl_n;
    logic       cas_n;
    logic [4:0] pin_in, pin_out, pin_oe;

    gpio_mux_port i_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .rst_por(rst_por), .hw_standby(hw_standby),
        .sw_standby(sw_standby), .hold_en(hold_en), .mode(mode), .dram_en(dram_en),
        .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ctl_n(bus_ctl_n), .cas_n(cas_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #5 clk = ~clk;

    typedef struct {
        string      req;
        int         what;   // 0 rdata, 1 pin_out, 2 pin_oe
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.what)
                0:       act = bus_rdata;
                1:       act = {3'b000, pin_out};
                default: act = {3'b000, pin_oe};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: sel %0d actual %02h expected %02h", it.req, it.what, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int what, input logic [7:0] exp);
        item_t it;
        it.req = req; it.what = what; it.exp = exp;
        q.push_back(it);
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] val);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = val;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] idx, input logic [7:0] exp);
        bus_idx = idx;
        chk(req, 0, exp);
    endtask

    task automatic por(input logic [2:0] m);
        rst_n = 1'b0; rst_por = 1'b1; mode = m;
        tick(2);
        rst_n = 1'b1; rst_por = 1'b0;
        tick(1);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rst_por = 1'b1; mode = 3'd4;
        hw_standby = 0; sw_standby = 0; hold_en = 0; dram_en = 0;
        bus_wr = 0; bus_idx = 0; bus_wdata = 0;
        bus_ctl_n = 4'b1010; cas_n = 1'b1; pin_in = 5'b0;
        tick(3);
        rst_n = 1'b1; rst_por = 1'b0;
        tick(1);
        // R1: mode 4 reset state
        chk("R1", 2, 8'h10);
        chk("R1", 1, 8'h10);
        rd("R1", 2'd1, 8'h00);
        rd("R4", 2'd0, 8'h00);

        mode = 3'd6;  // R11: not captured outside power-on reset
        wr(2'd0, 8'h1F);
        wr(2'd1, 8'h15);
        rd("R4", 2'd1, 8'h15);
        wr(2'd3, 8'hFF);
        rd("R4", 2'd1, 8'h15);
        // R5 + R7: strobes on pins 4..1, pin 0 general output
        chk("R5", 1, 8'h15);
        chk("R5", 2, 8'h1F);

        dram_en = 1'b1; cas_n = 1'b0;
        chk("R6", 1, 8'h14);
        chk("R6", 2, 8'h1F);
        wr(2'd0, 8'h1E);
        chk("R6", 2, 8'h1F);
        dram_en = 1'b0; cas_n = 1'b1;
        chk("R7", 2, 8'h1E);
        chk("R7", 1, 8'h14);

        pin_in = 5'b10110;
        rd("R4", 2'd2, 8'h16);
        rd("R4", 2'd3, 8'h00);

        // R2: manual reset
        rst_n = 1'b0; rst_por = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R2", 2, 8'h1E);
        rd("R2", 2'd1, 8'h00);

        // R9/R10: software standby
        wr(2'd0, 8'h1F);
        wr(2'd1, 8'h01);
        tick(1);
        sw_standby = 1'b1; hold_en = 1'b1; bus_ctl_n = 4'b0000;
        chk("R9", 1, 8'h15);
        chk("R9", 2, 8'h1F);
        hold_en = 1'b0;
        chk("R10", 2, 8'h01);
        chk("R10", 1, 8'h01);
        sw_standby = 1'b0;
        chk("R10", 2, 8'h1F);
        chk("R10", 1, 8'h01);

        // R3/R11: hardware standby reloads from the captured mode 4
        hw_standby = 1'b1;
        tick(1);
        chk("R3", 2, 8'h00);
        hw_standby = 1'b0;
        tick(1);
        chk("R11", 2, 8'h10);
        rd("R3", 2'd1, 8'h00);

        por(3'd6);
        chk("R1", 2, 8'h00);
        wr(2'd0, 8'h1F);
        chk("R5", 2, 8'h1F);
        chk("R5", 1, 8'h00);

        bus_ctl_n = 4'b0101; dram_en = 1'b1;
        por(3'd7);
        chk("R1", 2, 8'h00);
        wr(2'd0, 8'h1F);
        wr(2'd1, 8'h0A);
        chk("R8", 1, 8'h0A);
        chk("R8", 2, 8'h1F);

        dram_en = 1'b0;
        por(3'd5);
        chk("R1", 2, 8'h10);
        chk("R1", 1, 8'h00);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule